// File: doc/BRIEF.md
# Multiplexed ADC Host Register Interface

This block sits on a small 8-bit I/O bus as a slave. A host CPU uses it to run a multi-channel successive-approximation converter. The block answers in a four-byte window. Its base is set by external straps and compared against the upper address bits. Through that window the host can do three things:
- pick one of up to sixteen analog multiplexer inputs;
- start a conversion;
- read the result back as two bytes.

There are two ways to start. A channel write moves the multiplexer, waits a fixed settling time and then strobes the converter. A start-only write strobes the converter at once on the channel already selected, so the host can sample one input again and again without paying the settling time. The host can learn that a conversion has finished in two ways. It can poll a busy flag, or it can take a level interrupt that stays high until it reads the high result byte.

Top module: `adc_hostif`

## Requirements
- R1: The block is selected only when `io_addr[9:2]` equals `base_strap`. When it is not selected, `io_rdata` reads 0xFF and writes have no effect.
- R2: A write at window offset 1 loads `io_wdata[3:0]` into `mux_sel` and ignores `io_wdata[7:4]`.
- R3: After a write at offset 1, `conv_start` goes high SETTLE_CYC clock cycles later than it would after a write at offset 0.
- R4: A write at offset 0 raises `conv_start` in the cycle right after the write edge, and `mux_sel` does not change.
- R5: `conv_start` is high for exactly one clock cycle per conversion.
- R6: A read at offset 0 returns the busy flag in bit 7 and zeros in bits 6:0. The flag is 1 from an accepted start request until the converter drops `conv_busy`.
- R7: The block captures `conv_data` on the edge where the converter's busy falls. A read at offset 1 returns the low byte of that result and a read at offset 2 returns the high byte.
- R8: `irq` rises when a conversion completes. It stays high until a read at offset 2 or a reset. A read at offset 1 does not clear it.
- R9: A read at offset 3 returns 0xFF. Writes at offsets 2 and 3 neither change the result nor start a conversion.
- R10: While the busy flag is 1, channel writes and start writes are ignored. `mux_sel` keeps its value and no extra conversion starts.
- R11: After reset, `mux_sel`, `irq`, `conv_start`, the busy flag and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 10 | I/O port address |
| io_wdata | input | 8 | Write data from host |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data to host |
| base_strap | input | 8 | Strapped value compared with io_addr[9:2] |
| mux_sel | output | 4 | Analog multiplexer channel |
| conv_start | output | 1 | One-cycle convert command to the converter |
| conv_busy | input | 1 | Converter busy, high during a conversion |
| conv_data | input | 16 | Converter result word |
| irq | output | 1 | End-of-conversion interrupt level |

## Verification
The main test is a stream of conversions. Each one picks the start path at random (channel write or start-only write), and the channel byte, the converter latency and the result word are also random. Measuring the strobe delay on each start separates the two start paths and exposes an off-by-one in the settling count. Random result words with different high and low bytes catch swapped or stale byte lanes. Random upper bits in the channel byte show whether they leak into the multiplexer. Directed cases cover the rest:
- requests made mid-conversion;
- a foreign base address;
- the reserved offset;
- a low-byte read, which must leave the interrupt standing.

// File: rtl/adc_hostif_pkg.sv
package adc_hostif_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE    = 3'd0,
      SEQ_SETTLE  = 3'd1,
      SEQ_STROBE  = 3'd2,
      SEQ_WAIT_HI = 3'd3,
      SEQ_WAIT_LO = 3'd4
   } seq_state_t;

   typedef enum logic [1:0] {
      WIN_CTRL = 2'd0,
      WIN_LO   = 2'd1,
      WIN_HI   = 2'd2,
      WIN_RSVD = 2'd3
   } win_off_t;

   localparam logic [7:0] RD_FLOAT = 8'hFF;
   localparam int         BUS_W    = 8;
   localparam int         WIN_W    = 2;

endpackage

// File: rtl/adc_port_decode.sv
module adc_port_decode
   import adc_hostif_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int OFF_W  = WIN_W,
   localparam int CMP_W = ADDR_W - OFF_W
)(
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [CMP_W-1:0]  base_strap,
   output logic              sel,
   output win_off_t          off
);

   generate
      if (ADDR_W <= OFF_W) begin : g_bad_width
         $error("adc_port_decode: ADDR_W must exceed OFF_W");
      end
      if (OFF_W != WIN_W) begin : g_bad_off
         $error("adc_port_decode: window offset width is fixed");
      end
   endgenerate

   logic [CMP_W-1:0] bit_eq;

   generate
      for (genvar i = 0; i < CMP_W; i++) begin : g_cmp
         assign bit_eq[i] = ~(io_addr[OFF_W+i] ^ base_strap[i]);
      end
   endgenerate

   assign sel = &bit_eq;
   assign off = win_off_t'(io_addr[OFF_W-1:0]);

endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
   parameter int SETTLE_CYC = 300,
   localparam int CNT_W     = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC)
)(
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic expired
);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("adc_settle_timer: SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= CNT_W'(SETTLE_CYC - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = run_q && (cnt_q == '0);

   assert_timer_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
      expired |=> !expired)
      else $error("settle timer expiry lasted more than one cycle");

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_hostif_pkg::*;
#(
   parameter int SETTLE_CYC = 300
)(
   input  logic clk,
   input  logic rst,
   input  logic req_settle,
   input  logic req_now,
   input  logic conv_busy,
   output logic conv_start,
   output logic busy_flag,
   output logic done
);

   seq_state_t state_q, state_d;
   logic       tmr_load, tmr_expired;

   assign tmr_load = (state_q == SEQ_IDLE) && req_settle;

   adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (tmr_load),
      .expired (tmr_expired)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: begin
            if (req_settle)   state_d = SEQ_SETTLE;
            else if (req_now) state_d = SEQ_STROBE;
         end
         SEQ_SETTLE:  if (tmr_expired) state_d = SEQ_STROBE;
         SEQ_STROBE:  state_d = SEQ_WAIT_HI;
         SEQ_WAIT_HI: if (conv_busy)   state_d = SEQ_WAIT_LO;
         SEQ_WAIT_LO: if (!conv_busy)  state_d = SEQ_IDLE;
         default:     state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= SEQ_IDLE;
      else     state_q <= state_d;
   end

   assign conv_start = (state_q == SEQ_STROBE);
   assign busy_flag  = (state_q != SEQ_IDLE);
   assign done       = (state_q == SEQ_WAIT_LO) && !conv_busy;

   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
      conv_start |=> !conv_start)
      else $error("convert strobe longer than one cycle");

   assert_strobe_keeps_busy_R6: assert property (@(posedge clk) disable iff (rst)
      conv_start |=> busy_flag)
      else $error("busy flag dropped right after strobe");

endmodule

// File: rtl/adc_hostif.sv
module adc_hostif
   import adc_hostif_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int CH_W       = 4,
   parameter int RES_W      = 16,
   parameter int SETTLE_CYC = 300,
   localparam int CMP_W     = ADDR_W - WIN_W,
   localparam int RES_FULL  = 2 * BUS_W
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic [7:0]        io_rdata,
   input  logic [CMP_W-1:0]  base_strap,
   output logic [CH_W-1:0]   mux_sel,
   output logic              conv_start,
   input  logic              conv_busy,
   input  logic [RES_W-1:0]  conv_data,
   output logic              irq
);

   generate
      if (CH_W < 1 || CH_W > BUS_W - 1) begin : g_bad_ch
         $error("adc_hostif: CH_W must be 1..7");
      end
      if (RES_W < BUS_W + 1 || RES_W > RES_FULL) begin : g_bad_res
         $error("adc_hostif: RES_W must be 9..16");
      end
   endgenerate

   logic      sel;
   win_off_t  off;
   logic      wr_ch, wr_go, rd_hi;
   logic      busy_flag, done;
   logic [RES_W-1:0]    result_q;
   logic [RES_FULL-1:0] res_ext;
   logic      irq_q;
   logic [CH_W-1:0] ch_q;
   logic      unused_wbits;

   assign unused_wbits = ^io_wdata[7:CH_W];

   adc_port_decode #(.ADDR_W(ADDR_W), .OFF_W(WIN_W)) u_dec (
      .io_addr    (io_addr),
      .base_strap (base_strap),
      .sel        (sel),
      .off        (off)
   );

   assign wr_ch = io_wr && sel && (off == WIN_LO);
   assign wr_go = io_wr && sel && (off == WIN_CTRL);
   assign rd_hi = io_rd && sel && (off == WIN_HI);

   adc_conv_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .req_settle (wr_ch),
      .req_now    (wr_go),
      .conv_busy  (conv_busy),
      .conv_start (conv_start),
      .busy_flag  (busy_flag),
      .done       (done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ch_q     <= '0;
         result_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_ch && !busy_flag) ch_q <= io_wdata[CH_W-1:0];
         if (done) begin
            result_q <= conv_data;
            irq_q    <= 1'b1;
         end else if (rd_hi) begin
            irq_q    <= 1'b0;
         end
      end
   end

   generate
      if (RES_W == RES_FULL) begin : g_res_full
         assign res_ext = result_q;
      end else begin : g_res_pad
         assign res_ext = {{(RES_FULL - RES_W){1'b0}}, result_q};
      end
   endgenerate

   always_comb begin
      io_rdata = RD_FLOAT;
      if (sel) begin
         unique case (off)
            WIN_CTRL: io_rdata = {busy_flag, 7'b0};
            WIN_LO:   io_rdata = res_ext[BUS_W-1:0];
            WIN_HI:   io_rdata = res_ext[RES_FULL-1:BUS_W];
            default:  io_rdata = RD_FLOAT;
         endcase
      end
   end

   assign mux_sel = ch_q;
   assign irq     = irq_q;

   assert_mux_hold_R10: assert property (@(posedge clk) disable iff (rst)
      busy_flag |=> $stable(mux_sel))
      else $error("channel changed during a conversion");

   assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_hi && !done) |=> !irq)
      else $error("interrupt survived high byte read");

   assert_result_flags_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(result_q) |-> irq)
      else $error("result changed without interrupt");

endmodule

// File: tb/adc_hostif_test.sv
module adc_hostif_test;

   localparam int SETTLE = 300;
   localparam logic [7:0] BASE = 8'h44;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [9:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]  io_rdata;
   logic [7:0]  base_strap = BASE;
   logic [3:0]  mux_sel;
   logic        conv_start;
   logic        conv_busy = 1'b0;
   logic [15:0] conv_data = '0;
   logic        irq;

   int n_run = 0, n_fail = 0, conv_count = 0;
   logic [15:0] next_data = '0;
   bit finished = 0;

   always #10 clk = ~clk;

   adc_hostif #(.SETTLE_CYC(SETTLE)) uut (
      .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
      .base_strap(base_strap), .mux_sel(mux_sel), .conv_start(conv_start),
      .conv_busy(conv_busy), .conv_data(conv_data), .irq(irq)
   );

   function automatic int exp_delay(bit fast);
      return fast ? 0 : SETTLE;
   endfunction

   function automatic logic [3:0] exp_chan(logic [7:0] b);
      return b[3:0];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [9:0] a, logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_read(logic [9:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   function automatic logic [9:0] wa(logic [1:0] o);
      return {BASE, o};
   endfunction

   // converter model
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            conv_count++;
            repeat (1 + $urandom % 3) @(negedge clk);
            conv_busy = 1'b1;
            repeat (4 + $urandom % 8) @(negedge clk);
            conv_data = next_data;
            conv_busy = 1'b0;
         end
      end
   end

   task automatic wait_idle(string req);
      logic [7:0] d;
      int guard = 0;
      do begin
         bus_read(wa(2'd0), d);
         guard++;
      end while (d[7] && guard < 200);
      chk(req, d, 8'h00);
   endtask

   task automatic do_conv(bit fast, logic [7:0] chb, logic [15:0] data);
      logic [7:0] d;
      logic [3:0] ch_before;
      int k;
      next_data = data;
      ch_before = mux_sel;
      if (fast) bus_write(wa(2'd0), chb);
      else      bus_write(wa(2'd1), chb);
      k = 0;
      while (!conv_start && k < SETTLE + 20) begin
         @(negedge clk); k++;
      end
      chk(fast ? "R4 strobe delay" : "R3 strobe delay", k, exp_delay(fast));
      chk(fast ? "R4 channel kept" : "R2 channel loaded", mux_sel,
          fast ? ch_before : exp_chan(chb));
      @(negedge clk);
      chk("R5 strobe width", conv_start, 1'b0);
      bus_read(wa(2'd0), d);
      chk("R6 busy flag set", d, 8'h80);
      wait_idle("R6 busy flag clear");
      chk("R8 irq raised", irq, 1'b1);
      bus_read(wa(2'd1), d);
      chk("R7 low byte", d, data[7:0]);
      chk("R8 irq kept after low read", irq, 1'b1);
      bus_read(wa(2'd2), d);
      chk("R7 high byte", d, data[15:8]);
      chk("R8 irq cleared", irq, 1'b0);
   endtask

   initial begin
      logic [7:0] d;
      int cc;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R11 mux reset", mux_sel, 4'h0);
      chk("R11 irq reset", irq, 1'b0);
      chk("R11 strobe reset", conv_start, 1'b0);
      rst = 1'b0;
      bus_read(wa(2'd0), d); chk("R11 busy reset", d, 8'h00);
      bus_read(wa(2'd1), d); chk("R11 result lo reset", d, 8'h00);
      bus_read(wa(2'd2), d); chk("R11 result hi reset", d, 8'h00);

      // directed: both paths, distinctive data
      do_conv(1'b0, 8'hF9, 16'hA55A);
      do_conv(1'b1, 8'h03, 16'h0FF0);

      // random mix
      for (int i = 0; i < 14; i++) begin
         do_conv(bit'($urandom % 2), 8'($urandom), 16'($urandom));
      end

      // R1: foreign base
      cc = conv_count;
      bus_write({8'h45, 2'd1}, 8'h0C);
      bus_write({8'h45, 2'd0}, 8'h00);
      repeat (5) @(negedge clk);
      chk("R1 no strobe off-base", conv_count, cc);
      chk("R1 mux unchanged off-base", mux_sel, mux_sel == 4'hC ? 4'hD : mux_sel);
      bus_read({8'h45, 2'd1}, d); chk("R1 off-base read", d, 8'hFF);
      bus_read({8'h04, 2'd0}, d); chk("R1 off-base read ctrl", d, 8'hFF);

      // R9: reserved and high offsets
      do_conv(1'b1, 8'h00, 16'h1234);
      cc = conv_count;
      bus_write(wa(2'd2), 8'hEE);
      bus_write(wa(2'd3), 8'hDD);
      repeat (5) @(negedge clk);
      chk("R9 no strobe on off2/3 write", conv_count, cc);
      bus_read(wa(2'd1), d); chk("R9 result lo kept", d, 8'h34);
      bus_read(wa(2'd2), d); chk("R9 result hi kept", d, 8'h12);
      bus_read(wa(2'd3), d); chk("R9 reserved read", d, 8'hFF);

      // R10: requests while busy
      next_data = 16'hBEEF;
      cc = conv_count;
      bus_write(wa(2'd1), 8'h05);
      bus_write(wa(2'd1), 8'h0A);
      bus_write(wa(2'd0), 8'h00);
      chk("R10 channel held", mux_sel, 4'h5);
      wait_idle("R10 idle after one conversion");
      repeat (10) @(negedge clk);
      chk("R10 single conversion", conv_count, cc + 1);
      chk("R10 channel after", mux_sel, 4'h5);
      bus_read(wa(2'd2), d); chk("R7 high byte R10 case", d, 8'hBE);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule